// File: doc/BRIEF.md
# SONET Path Overhead Monitor

This block watches the path overhead of one STS-1 time slot after the bytes have been pulled out of the frame upstream. Each byte arrives with its own one-cycle strobe. The B3 byte is compared with a BIP-8 value that an outside stage computed over the previous frame's payload. Mismatches go into a 16-bit saturating counter. That counter can count single bit errors or whole errored frames.

The G1 byte carries the path remote defect indication. The block reads it either as a single defect bit or as a 3-bit enhanced code. A code must be seen in five consecutive frames before the reported status follows it. When trace capture is enabled, the J1 byte is held in an output register.

The three mode controls are sampled only on a frame-start pulse. A change therefore never splits a frame between two settings.

Top module: `povMonitor`

## Requirements
- R1: After reset, errCount is 0, rdiActive is 0, rdiCode is 000 and j1Captured is 0x00. The sampled modes are bit counting, 1-bit defect monitoring and capture disabled.
- R2: In bit mode, each b3Valid strobe adds the number of 1 bits in (b3Byte XOR bipCalc) to errCount. The result is visible in the cycle after the strobe, and the counter is unchanged while neither b3Valid nor errClr is high.
- R3: In block mode, each b3Valid strobe adds exactly 1 when b3Byte differs from bipCalc in any bit, and adds 0 when they are equal.
- R4: errCount saturates at 0xFFFF and stays there until it is cleared.
- R5: errClr loads 0 into errCount. If b3Valid is high in the same cycle, errCount loads that frame's increment instead.
- R6: In 1-bit mode the frame's defect code is {g1Byte[3], 0, 0}, and g1Byte bits 2 and 1 have no effect.
- R7: In enhanced mode the frame's defect code is g1Byte[3:1]. rdiCode reports the accepted code, and rdiActive is high when bit 2 or bit 1 of the accepted code is set (codes 000 and 001 mean no defect).
- R8: A defect code is accepted only after it has arrived on five consecutive g1Valid strobes. A different code restarts the run. The accepted code and rdiActive change in the cycle after the fifth strobe and at no other time.
- R9: While capture is enabled, each j1Valid strobe loads j1Byte into j1Captured. While capture is disabled, j1Captured holds its value.
- R10: The modeBlock, modeEnh and j1DumpEn inputs take effect only at a frameStart pulse and are held from one pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame boundary pulse; samples the mode inputs |
| modeBlock | input | 1 | 1 = count errored frames, 0 = count bit errors |
| modeEnh | input | 1 | 1 = enhanced 3-bit defect code, 0 = 1-bit defect |
| j1DumpEn | input | 1 | 1 = capture J1 bytes |
| b3Valid | input | 1 | B3 byte strobe |
| b3Byte | input | 8 | Received B3 byte |
| bipCalc | input | 8 | BIP-8 computed over the previous frame |
| g1Valid | input | 1 | G1 byte strobe |
| g1Byte | input | 8 | Received G1 byte |
| j1Valid | input | 1 | J1 byte strobe |
| j1Byte | input | 8 | Received J1 byte |
| errClr | input | 1 | Read-clear strobe for the error counter |
| errCount | output | 16 | B3 error counter |
| rdiActive | output | 1 | Accepted remote defect status |
| rdiCode | output | 3 | Accepted defect code |
| j1Captured | output | 8 | Last captured J1 byte |

## Verification
The parity stage is driven with several kinds of B3/BIP-8 pair: identical bytes, a single flipped bit, all eight bits flipped, and scattered mismatches. Running the same pairs in both counting modes tells a popcount apart from a plain any-error flag.

The defect filter gets runs of four matching codes followed by a different code, then a full run of five. This separates the restart rule from simple counting. G1 values with only bits 2..1 set show whether the 1-bit mode really ignores those bits.

Mode bits are changed without a frame pulse and then with one, to show that they take effect only at a frame boundary.

// File: rtl/pov_pkg.sv
package pov_pkg;
  typedef struct packed {
    logic b3Eval;
    logic g1Eval;
    logic j1Load;
    logic blockMode;
    logic enhMode;
  } povStrobes_t;
endpackage

// File: rtl/pov_ctrl.sv
module pov_ctrl
  import pov_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        modeBlock,
  input  logic        modeEnh,
  input  logic        j1DumpEn,
  input  logic        b3Valid,
  input  logic        g1Valid,
  input  logic        j1Valid,
  output povStrobes_t strobes
);
  logic actBlock, actEnh, actDump;

  // mode controls are frozen between frame boundaries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actBlock <= 1'b0;
      actEnh   <= 1'b0;
      actDump  <= 1'b0;
    end else if (frameStart) begin
      actBlock <= modeBlock;
      actEnh   <= modeEnh;
      actDump  <= j1DumpEn;
    end
  end

  always_comb begin
    strobes.b3Eval    = b3Valid;
    strobes.g1Eval    = g1Valid;
    strobes.j1Load    = j1Valid & actDump;
    strobes.blockMode = actBlock;
    strobes.enhMode   = actEnh;
  end
endmodule

// File: rtl/pov_datapath.sv
module pov_datapath
  import pov_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 16,
  parameter int PERSIST = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  povStrobes_t       strobes,
  input  logic [BYTE_W-1:0] b3Byte,
  input  logic [BYTE_W-1:0] bipCalc,
  input  logic [BYTE_W-1:0] g1Byte,
  input  logic [BYTE_W-1:0] j1Byte,
  input  logic              errClr,
  output logic [CNT_W-1:0]  errCount,
  output logic              rdiActive,
  output logic [2:0]        rdiCode,
  output logic [BYTE_W-1:0] j1Captured
);
  localparam int IW = $clog2(BYTE_W + 1);
  localparam int PW = $clog2(PERSIST + 1);

  // ---------------- B3 parity ----------------
  logic [BYTE_W-1:0] parDiff;
  logic [IW-1:0]     bitErrs;
  logic [IW-1:0]     frameInc;
  logic [CNT_W:0]    sumWide;

  always_comb begin
    parDiff = b3Byte ^ bipCalc;
    bitErrs = '0;
    for (int i = 0; i < BYTE_W; i++) bitErrs = bitErrs + IW'(parDiff[i]);
    if (!strobes.b3Eval)         frameInc = '0;
    else if (strobes.blockMode)  frameInc = IW'(|parDiff);
    else                         frameInc = bitErrs;
    sumWide = {1'b0, errCount} + (CNT_W + 1)'(frameInc);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                errCount <= '0;
    else if (errClr)          errCount <= CNT_W'(frameInc);
    else if (sumWide[CNT_W])  errCount <= '1;
    else                      errCount <= sumWide[CNT_W-1:0];
  end

  // ---------------- G1 defect filter ----------------
  logic [2:0]    frameCode, candCode;
  logic [PW-1:0] matchCnt, nextCnt;

  always_comb begin
    frameCode = strobes.enhMode ? g1Byte[3:1] : {g1Byte[3], 2'b00};
    if (frameCode != candCode)           nextCnt = PW'(1);
    else if (matchCnt == PW'(PERSIST))   nextCnt = matchCnt;
    else                                 nextCnt = matchCnt + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candCode <= 3'b000;
      matchCnt <= '0;
      rdiCode  <= 3'b000;
    end else if (strobes.g1Eval) begin
      candCode <= frameCode;
      matchCnt <= nextCnt;
      if (nextCnt == PW'(PERSIST)) rdiCode <= frameCode;
    end
  end

  assign rdiActive = rdiCode[2] | rdiCode[1];

  // ---------------- J1 capture ----------------
  always_ff @(posedge clk) begin
    if (!rstN)               j1Captured <= '0;
    else if (strobes.j1Load) j1Captured <= j1Byte;
  end
endmodule

// File: rtl/povMonitor.sv
module povMonitor
  import pov_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 16,
  parameter int PERSIST = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              modeBlock,
  input  logic              modeEnh,
  input  logic              j1DumpEn,
  input  logic              b3Valid,
  input  logic [BYTE_W-1:0] b3Byte,
  input  logic [BYTE_W-1:0] bipCalc,
  input  logic              g1Valid,
  input  logic [BYTE_W-1:0] g1Byte,
  input  logic              j1Valid,
  input  logic [BYTE_W-1:0] j1Byte,
  input  logic              errClr,
  output logic [CNT_W-1:0]  errCount,
  output logic              rdiActive,
  output logic [2:0]        rdiCode,
  output logic [BYTE_W-1:0] j1Captured
);
  povStrobes_t strobes;

  pov_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .modeBlock(modeBlock), .modeEnh(modeEnh), .j1DumpEn(j1DumpEn),
    .b3Valid(b3Valid), .g1Valid(g1Valid), .j1Valid(j1Valid),
    .strobes(strobes)
  );

  pov_datapath #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .PERSIST(PERSIST)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .b3Byte(b3Byte), .bipCalc(bipCalc), .g1Byte(g1Byte), .j1Byte(j1Byte),
    .errClr(errClr), .errCount(errCount), .rdiActive(rdiActive),
    .rdiCode(rdiCode), .j1Captured(j1Captured)
  );
endmodule

// File: rtl/povMonitor_chk.sv
module povMonitor_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              b3Valid,
  input logic              g1Valid,
  input logic              j1Valid,
  input logic              errClr,
  input logic [CNT_W-1:0]  errCount,
  input logic              rdiActive,
  input logic [2:0]        rdiCode,
  input logic [BYTE_W-1:0] j1Captured
);
  assert_count_monotone_R2: assert property (@(posedge clk) disable iff (!rstN)
    !errClr |=> errCount >= $past(errCount));

  assert_count_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!b3Valid && !errClr) |=> $stable(errCount));

  assert_hold_sat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == {CNT_W{1'b1}} && !errClr) |=> errCount == {CNT_W{1'b1}});

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !b3Valid) |=> errCount == '0);

  assert_rdi_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !g1Valid |=> ($stable(rdiActive) && $stable(rdiCode)));

  assert_j1_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !j1Valid |=> $stable(j1Captured));
endmodule

bind povMonitor povMonitor_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .b3Valid(b3Valid), .g1Valid(g1Valid),
  .j1Valid(j1Valid), .errClr(errClr), .errCount(errCount),
  .rdiActive(rdiActive), .rdiCode(rdiCode), .j1Captured(j1Captured)
);

// File: tb/povMonitor_bench.sv
module povMonitor_bench;
  localparam int PERIOD = 10;
  localparam int NV = 7;
  // {blockMode, b3Byte, bipCalc, expected count}
  localparam logic [20:0] VECS [NV] = '{
    {1'b0, 8'hFF, 8'h00, 4'd8},
    {1'b0, 8'hA5, 8'hA5, 4'd0},
    {1'b0, 8'h01, 8'h00, 4'd1},
    {1'b0, 8'h12, 8'h34, 4'd3},
    {1'b1, 8'hFF, 8'h00, 4'd1},
    {1'b1, 8'h3C, 8'h00, 4'd1},
    {1'b1, 8'h55, 8'h55, 4'd0}
  };

  logic clk = 0, rstN = 0;
  logic frameStart = 0, modeBlock = 0, modeEnh = 0, j1DumpEn = 0;
  logic b3Valid = 0, g1Valid = 0, j1Valid = 0, errClr = 0;
  logic [7:0] b3Byte = 0, bipCalc = 0, g1Byte = 0, j1Byte = 0;
  logic [15:0] errCount;
  logic rdiActive;
  logic [2:0] rdiCode;
  logic [7:0] j1Captured;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  povMonitor u_povMonitor (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .modeBlock(modeBlock),
    .modeEnh(modeEnh), .j1DumpEn(j1DumpEn), .b3Valid(b3Valid), .b3Byte(b3Byte),
    .bipCalc(bipCalc), .g1Valid(g1Valid), .g1Byte(g1Byte), .j1Valid(j1Valid),
    .j1Byte(j1Byte), .errClr(errClr), .errCount(errCount),
    .rdiActive(rdiActive), .rdiCode(rdiCode), .j1Captured(j1Captured)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic newFrame(logic blk, logic enh, logic dmp);
    modeBlock = blk; modeEnh = enh; j1DumpEn = dmp; frameStart = 1;
    step();
    frameStart = 0;
  endtask

  task automatic sendG1(logic [7:0] v, int n);
    for (int i = 0; i < n; i++) begin
      g1Byte = v; g1Valid = 1;
      step();
      g1Valid = 0;
    end
  endtask

  task automatic sendB3(logic [7:0] b, logic [7:0] p);
    b3Byte = b; bipCalc = p; b3Valid = 1;
    step();
    b3Valid = 0;
  endtask

  task automatic clearCnt();
    errClr = 1;
    step();
    errClr = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    rstN = 1;
    step();
    // R1 reset state
    check("R1 count", errCount, 0);
    check("R1 rdi", rdiActive, 0);
    check("R1 code", rdiCode, 0);
    check("R1 j1", j1Captured, 0);
    sendB3(8'h0F, 8'h00);
    check("R1 default bit mode", errCount, 4);

    // table walk: R2 bit mode, R3 block mode
    for (int k = 0; k < NV; k++) begin
      modeBlock = VECS[k][20]; frameStart = 1; errClr = 1;
      step();
      frameStart = 0; errClr = 0;
      sendB3(VECS[k][19:12], VECS[k][11:4]);
      check(VECS[k][20] ? "R3 block vector" : "R2 bit vector",
            errCount, 32'(VECS[k][3:0]));
    end

    // R2 accumulation
    newFrame(0, 0, 0); clearCnt();
    sendB3(8'hFF, 8'h00); sendB3(8'hFF, 8'h00); sendB3(8'h03, 8'h00);
    check("R2 accumulate", errCount, 18);
    step();
    check("R2 idle hold", errCount, 18);

    // R10: mode change without frame pulse does nothing
    modeBlock = 1;
    sendB3(8'hFF, 8'h00);
    check("R10 mode held", errCount, 26);
    newFrame(1, 0, 0);
    sendB3(8'hFF, 8'h00);
    check("R10 mode applied", errCount, 27);

    // R5 clear with simultaneous error
    newFrame(0, 0, 0);
    b3Byte = 8'h07; bipCalc = 8'h00; b3Valid = 1; errClr = 1;
    step();
    b3Valid = 0; errClr = 0;
    check("R5 clear with error", errCount, 3);
    clearCnt();
    check("R5 clear", errCount, 0);

    // R4 saturation
    b3Byte = 8'hFF; bipCalc = 8'h00; b3Valid = 1;
    for (int i = 0; i < 8192; i++) step();
    b3Valid = 0;
    check("R4 saturate", errCount, 16'hFFFF);
    sendB3(8'hFF, 8'h00);
    check("R4 hold at max", errCount, 16'hFFFF);
    clearCnt();

    // R8 restart, R6 one-bit mode
    sendG1(8'h08, 4); sendG1(8'h00, 1); sendG1(8'h08, 4);
    check("R8 restart after break", rdiActive, 0);
    sendG1(8'h08, 1);
    check("R8 set after five", rdiActive, 1);
    check("R6 code", rdiCode, 3'b100);
    sendG1(8'h06, 4);
    check("R8 hold during clear run", rdiActive, 1);
    sendG1(8'h06, 1);
    check("R6 bits 2..1 ignored", rdiActive, 0);
    check("R6 code cleared", rdiCode, 0);

    // R7 enhanced mode
    newFrame(0, 1, 0);
    sendG1(8'h04, 5);
    check("R7 enhanced active", rdiActive, 1);
    check("R7 enhanced code", rdiCode, 3'b010);
    sendG1(8'h02, 5);
    check("R7 code 001 no defect", rdiActive, 0);
    check("R7 code 001 reported", rdiCode, 3'b001);

    // R9 J1 capture
    j1Byte = 8'hAB; j1Valid = 1; step(); j1Valid = 0;
    check("R9 disabled ignores", j1Captured, 0);
    newFrame(0, 0, 1);
    j1Byte = 8'h5C; j1Valid = 1; step(); j1Valid = 0;
    check("R9 captured", j1Captured, 8'h5C);
    j1DumpEn = 0;
    j1Byte = 8'h11; j1Valid = 1; step(); j1Valid = 0;
    check("R10 dump held until frame", j1Captured, 8'h11);
    newFrame(0, 0, 0);
    j1Byte = 8'h22; j1Valid = 1; step(); j1Valid = 0;
    check("R9 disabled after frame", j1Captured, 8'h11);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule